// File: doc/BRIEF.md
# Codec power-state and slot-output controller

This block is the digital control core of a telephony voice codec. It holds the codec's power state and decodes power commands that arrive as control bytes from one of two control ports. A mode pin picks the port: a monitor-channel byte stream or a serial control port. Multi-byte instructions also write a small bank of control registers. These registers keep their contents across power cycles.

The block gates the tristate enable of the serial voice-data output. The output drives only during its selected time slot, and only after two frame syncs have been seen since the last power-up. The whole block runs from a free-running reference clock. The master clock is sampled as a signal and watched for activity. If the master clock goes quiet for a fixed number of reference cycles, the codec is forced into a reset power-down state. It stays there until a power command arrives while the master clock is running again.

Top module: `codec_pwr_ctrl`

## Requirements
- R1: After reset the block is powered down (`pwr_down`=1). `codec_en`, `lo_oe`, `dx_oe` and `clk_lost` are 0, and every control register reads 0x00.
- R2: A byte flagged last that is not part of a longer instruction is a single-byte instruction. If its bit 1 is 0, it is a power command: bit 2 = 0 powers up and bit 2 = 1 powers down. The new state is visible in the cycle after the byte is accepted.
- R3: A single-byte instruction with bit 1 = 1 changes neither the power state nor any register.
- R4: In a longer instruction, the first byte is a header. Its bits 5:3 give a register address and its bit 2 is the power bit. Data byte k (k = 1, 2, ...) writes register (address + k - 1) mod 8. The power bit takes effect only after the byte flagged last.
- R5: `dx_oe` is 1 only while powered up and `slot_active` is 1, and only after at least two rising edges of `fsync` have been counted since power-up.
- R6: The frame-sync count is cleared while powered down. An `fsync` rising edge in the same cycle as the power-up byte is not counted.
- R7: Power-down by instruction leaves every register unchanged, and registers can still be written while powered down.
- R8: `mode_sel`=0 takes bytes from the monitor port and `mode_sel`=1 takes bytes from the serial port. Bytes on the port that is not selected are ignored.
- R9: After 64 reference cycles with no `mclk` edge, the block sets `clk_lost` and forces `pwr_down`=1. In that state `codec_en`, `lo_oe` and `dx_oe` are 0, and the registers keep their contents.
- R10: The loss state is left only by a power command accepted while `mclk` edges are present. Power commands received while `mclk` is still absent are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| mclk | input | 1 | Master clock, sampled for activity |
| fsync | input | 1 | Frame sync, counted on rising edges |
| slot_active | input | 1 | High during the selected voice time slot |
| mode_sel | input | 1 | Control port select: 0 monitor, 1 serial |
| mon_valid | input | 1 | Monitor-port byte strobe |
| mon_byte | input | 8 | Monitor-port byte |
| mon_last | input | 1 | Monitor-port byte ends its instruction |
| ser_valid | input | 1 | Serial-port byte strobe |
| ser_byte | input | 8 | Serial-port byte |
| ser_last | input | 1 | Serial-port byte ends its instruction |
| reg_rd_addr | input | 3 | Control register read address |
| reg_rd_data | output | 8 | Control register read data |
| pwr_down | output | 1 | 1 = powered down |
| codec_en | output | 1 | Codec functions enabled |
| lo_oe | output | 1 | Line-driver output enable |
| dx_oe | output | 1 | Voice-data output enable |
| clk_lost | output | 1 | Reset power-down state after master-clock loss |

## Verification
Two events can fall in the same cycle: the frame-sync edge and the power-up command. The bench provokes this by raising `fsync` in the same cycle as a power-up byte. It then checks that one further frame sync is not enough and that the second one enables `dx_oe`. A second collision is between a power command and a missing master clock. The bench sends a power-up command while `mclk` is stopped and checks that the loss state holds. After `mclk` restarts, the same command must bring the codec up. A sweep of all 256 single-byte values, from both power states, checks the power decode against a model of R2 and R3.

// File: rtl/codec_pc_pkg.sv
package codec_pc_pkg;
  localparam int BYTE_W   = 8;
  localparam int P_BIT    = 2;   // power bit: 0 up, 1 down
  localparam int NOPWR_BIT = 1;  // single byte: 1 = not a power command
  localparam int ADDR_LSB = 3;   // header register address field

  typedef struct packed {
    logic              valid;
    logic              last;
    logic [BYTE_W-1:0] data;
  } ctl_beat_t;
endpackage

// File: rtl/codec_port_sel.sv
module codec_port_sel
  import codec_pc_pkg::*;
(
  input  logic              mode_sel,
  input  logic              mon_valid,
  input  logic [BYTE_W-1:0] mon_byte,
  input  logic              mon_last,
  input  logic              ser_valid,
  input  logic [BYTE_W-1:0] ser_byte,
  input  logic              ser_last,
  output ctl_beat_t         beat
);
  always_comb begin
    if (mode_sel) begin
      beat.valid = ser_valid;
      beat.last  = ser_last;
      beat.data  = ser_byte;
    end else begin
      beat.valid = mon_valid;
      beat.last  = mon_last;
      beat.data  = mon_byte;
    end
  end
endmodule

// File: rtl/codec_instr_dec.sv
module codec_instr_dec
  import codec_pc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_beat_t         beat,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              pcmd_valid,
  output logic              pcmd_down
);
  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              pbit_q, pbit_d;

  always_comb begin
    busy_d     = busy_q;
    ptr_d      = ptr_q;
    pbit_d     = pbit_q;
    wr_en      = 1'b0;
    wr_addr    = ptr_q;
    wr_data    = beat.data;
    pcmd_valid = 1'b0;
    pcmd_down  = pbit_q;
    if (beat.valid) begin
      if (!busy_q) begin
        if (beat.last) begin
          pcmd_valid = ~beat.data[NOPWR_BIT];
          pcmd_down  = beat.data[P_BIT];
        end else begin
          busy_d = 1'b1;
          ptr_d  = beat.data[ADDR_LSB +: ADDR_W];
          pbit_d = beat.data[P_BIT];
        end
      end else begin
        wr_en = 1'b1;
        ptr_d = ptr_q + ADDR_W'(1);
        if (beat.last) begin
          busy_d     = 1'b0;
          pcmd_valid = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      pbit_q <= 1'b1;
    end else begin
      busy_q <= busy_d;
      ptr_q  <= ptr_d;
      pbit_q <= pbit_d;
    end
  end
endmodule

// File: rtl/codec_clk_watch.sv
module codec_clk_watch #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk,
  output logic mclk_absent
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

  logic [2:0]       smp_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             edge_seen;

  assign edge_seen = smp_q[1] ^ smp_q[2];

  always_comb begin
    cnt_d = cnt_q;
    if (edge_seen)          cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      cnt_q <= '0;
    end else begin
      smp_q <= {smp_q[1:0], mclk};
      cnt_q <= cnt_d;
    end
  end

  assign mclk_absent = (cnt_q == LIMIT);
endmodule

// File: rtl/codec_slot_gate.sv
module codec_slot_gate #(
  parameter int FS_NEED = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync,
  input  logic powered_up,
  input  logic slot_active,
  output logic dx_oe
);
  localparam int FW = $clog2(FS_NEED + 1);
  localparam logic [FW-1:0] NEED = FW'(FS_NEED);

  logic          fs_prev_q;
  logic [FW-1:0] fs_cnt_q, fs_cnt_d;

  always_comb begin
    fs_cnt_d = fs_cnt_q;
    if (!powered_up)
      fs_cnt_d = '0;
    else if (fsync && !fs_prev_q && fs_cnt_q != NEED)
      fs_cnt_d = fs_cnt_q + FW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev_q <= 1'b0;
      fs_cnt_q  <= '0;
    end else begin
      fs_prev_q <= fsync;
      fs_cnt_q  <= fs_cnt_d;
    end
  end

  assign dx_oe = powered_up & slot_active & (fs_cnt_q == NEED);
endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl
  import codec_pc_pkg::*;
#(
  parameter int ADDR_W       = 3,
  parameter int LOSS_TIMEOUT = 64,
  parameter int FS_NEED      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclk,
  input  logic              fsync,
  input  logic              slot_active,
  input  logic              mode_sel,
  input  logic              mon_valid,
  input  logic [BYTE_W-1:0] mon_byte,
  input  logic              mon_last,
  input  logic              ser_valid,
  input  logic [BYTE_W-1:0] ser_byte,
  input  logic              ser_last,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [BYTE_W-1:0] reg_rd_data,
  output logic              pwr_down,
  output logic              codec_en,
  output logic              lo_oe,
  output logic              dx_oe,
  output logic              clk_lost
);
  localparam int REG_N = 1 << ADDR_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ctl_beat_t         beat;
  logic              wr_en, pcmd_valid, pcmd_down, mclk_absent;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;

  codec_port_sel u_sel (
    .mode_sel (mode_sel),
    .mon_valid(mon_valid), .mon_byte(mon_byte), .mon_last(mon_last),
    .ser_valid(ser_valid), .ser_byte(ser_byte), .ser_last(ser_last),
    .beat     (beat)
  );

  codec_instr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .beat(beat),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pcmd_valid(pcmd_valid), .pcmd_down(pcmd_down)
  );

  codec_clk_watch #(.TIMEOUT(LOSS_TIMEOUT)) u_watch (
    .clk(clk), .rst_n(rst_int_n), .mclk(mclk), .mclk_absent(mclk_absent)
  );

  // control register bank
  logic [BYTE_W-1:0] regs_q [REG_N];
  logic [BYTE_W-1:0] regs_d [REG_N];

  always_comb begin
    for (int i = 0; i < REG_N; i++) begin
      regs_d[i] = regs_q[i];
      if (wr_en && wr_addr == ADDR_W'(i)) regs_d[i] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int i = 0; i < REG_N; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 0; i < REG_N; i++) regs_q[i] <= regs_d[i];
    end
  end

  assign reg_rd_data = regs_q[reg_rd_addr];

  // power state: clock loss outranks any command
  logic pwr_down_q, pwr_down_d, lost_q, lost_d;

  always_comb begin
    pwr_down_d = pwr_down_q;
    lost_d     = lost_q;
    if (mclk_absent) begin
      pwr_down_d = 1'b1;
      lost_d     = 1'b1;
    end else if (pcmd_valid) begin
      pwr_down_d = pcmd_down;
      lost_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pwr_down_q <= 1'b1;
      lost_q     <= 1'b0;
    end else begin
      pwr_down_q <= pwr_down_d;
      lost_q     <= lost_d;
    end
  end

  codec_slot_gate #(.FS_NEED(FS_NEED)) u_gate (
    .clk(clk), .rst_n(rst_int_n), .fsync(fsync),
    .powered_up(~pwr_down_q), .slot_active(slot_active), .dx_oe(dx_oe)
  );

  assign pwr_down = pwr_down_q;
  assign clk_lost = lost_q;
  assign codec_en = ~pwr_down_q;
  assign lo_oe    = ~pwr_down_q & ~lost_q;
endmodule

// File: rtl/codec_pwr_ctrl_chk.sv
module codec_pwr_ctrl_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_sel,
  input logic              mon_valid,
  input logic              mon_last,
  input logic              ser_valid,
  input logic              ser_last,
  input logic              slot_active,
  input logic [ADDR_W-1:0] reg_rd_addr,
  input logic [7:0]        reg_rd_data,
  input logic              pwr_down,
  input logic              codec_en,
  input logic              lo_oe,
  input logic              dx_oe,
  input logic              clk_lost
);
  p_dx_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dx_oe |-> (!pwr_down && slot_active));

  p_loss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_lost |-> (pwr_down && !codec_en && !lo_oe && !dx_oe));

  p_reg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_valid && !ser_valid) |=> (!$stable(reg_rd_addr) || $stable(reg_rd_data)));

  p_up_by_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> $past(mode_sel ? (ser_valid && ser_last) : (mon_valid && mon_last)));

  p_fresh_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> !dx_oe);
endmodule

bind codec_pwr_ctrl codec_pwr_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/codec_pwr_ctrl_tb_top.sv
module codec_pwr_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, mclk, mclk_run, fsync, slot_active, mode_sel;
  logic       mon_valid, mon_last, ser_valid, ser_last;
  logic [7:0] mon_byte, ser_byte, reg_rd_data;
  logic [2:0] reg_rd_addr;
  logic       pwr_down, codec_en, lo_oe, dx_oe, clk_lost;
  int         errors = 0, checks = 0;
  logic [7:0] m_regs [8];

  always #5 clk = ~clk;
  always begin
    #20;
    if (mclk_run) mclk = ~mclk;
  end

  codec_pwr_ctrl dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic ser, input logic [7:0] b, input logic last);
    @(negedge clk);
    if (ser) begin ser_valid = 1; ser_byte = b; ser_last = last; end
    else     begin mon_valid = 1; mon_byte = b; mon_last = last; end
    @(negedge clk);
    mon_valid = 0; ser_valid = 0; mon_last = 0; ser_last = 0;
  endtask

  task automatic fs_pulse();
    @(negedge clk); fsync = 1;
    @(negedge clk); fsync = 0;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
    reg_rd_addr = a; #1;
    chk(req, reg_rd_data, exp);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; mclk = 0; mclk_run = 1; fsync = 0; slot_active = 0; mode_sel = 0;
    mon_valid = 0; mon_last = 0; ser_valid = 0; ser_last = 0;
    mon_byte = 0; ser_byte = 0; reg_rd_addr = 0;
    for (int i = 0; i < 8; i++) m_regs[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 pwr_down", pwr_down, 1); chk("R1 codec_en", codec_en, 0);
    chk("R1 lo_oe", lo_oe, 0); chk("R1 dx_oe", dx_oe, 0); chk("R1 clk_lost", clk_lost, 0);
    for (int i = 0; i < 8; i++) chk_reg("R1 reg", 3'(i), 8'h00);

    // R2 power-up by single byte
    send(0, 8'h00, 1);
    chk("R2 up", pwr_down, 0); chk("R2 codec_en", codec_en, 1); chk("R2 lo_oe", lo_oe, 1);

    // R5 output gating by two frame syncs and slot
    slot_active = 1; #1; chk("R5 no fs", dx_oe, 0);
    fs_pulse(); chk("R5 one fs", dx_oe, 0);
    fs_pulse(); chk("R5 two fs", dx_oe, 1);
    slot_active = 0; #1; chk("R5 off slot", dx_oe, 0);
    slot_active = 1; #1;

    // R3 single byte with bit1 set
    send(0, 8'h06, 1);
    chk("R3 no power change", pwr_down, 0); chk("R3 dx kept", dx_oe, 1);

    // R4 multi-byte, power after last byte
    send(0, 8'h1C, 0);
    chk("R4 not yet down", pwr_down, 0);
    send(0, 8'hA5, 1); m_regs[3] = 8'hA5;
    chk("R4 down at end", pwr_down, 1); chk("R4 dx off", dx_oe, 0);
    chk_reg("R4 reg3", 3, 8'hA5);

    // R7 write while down, keep across power cycle
    send(0, 8'h24, 0); send(0, 8'h3C, 1); m_regs[4] = 8'h3C;
    chk_reg("R7 reg4 while down", 4, 8'h3C); chk("R7 still down", pwr_down, 1);
    send(0, 8'h30, 0); send(0, 8'h11, 0); send(0, 8'h22, 1);
    m_regs[6] = 8'h11; m_regs[7] = 8'h22;
    chk("R4 up after last", pwr_down, 0);
    chk_reg("R4 reg6", 6, 8'h11); chk_reg("R4 reg7", 7, 8'h22);
    chk_reg("R7 reg3 kept", 3, 8'hA5); chk_reg("R7 reg4 kept", 4, 8'h3C);
    send(0, 8'h3C, 0); send(0, 8'h55, 0); send(0, 8'h66, 1);
    m_regs[7] = 8'h55; m_regs[0] = 8'h66;
    chk_reg("R4 wrap reg7", 7, 8'h55); chk_reg("R4 wrap reg0", 0, 8'h66);
    chk("R4 down", pwr_down, 1);

    // R6 fsync edge together with power-up byte is not counted
    @(negedge clk); mon_valid = 1; mon_byte = 8'h00; mon_last = 1; fsync = 1;
    @(negedge clk); mon_valid = 0; mon_last = 0; fsync = 0;
    chk("R6 up", pwr_down, 0); chk("R6 dx after up", dx_oe, 0);
    fs_pulse(); chk("R6 one more fs", dx_oe, 0);
    fs_pulse(); chk("R6 second fs", dx_oe, 1);

    // R8 mode select
    send(1, 8'h04, 1); chk("R8 serial ignored", pwr_down, 0);
    mode_sel = 1;
    send(1, 8'h04, 1); chk("R8 serial used", pwr_down, 1);
    send(0, 8'h00, 1); chk("R8 monitor ignored", pwr_down, 1);
    send(1, 8'h00, 1); chk("R8 serial up", pwr_down, 0);
    mode_sel = 0;

    // R2/R3 sweep over all single-byte values from both states
    for (int b = 0; b < 256; b++) begin
      logic [7:0] v = 8'(b);
      logic pre = v[0];
      send(0, {5'b0, pre, 2'b00}, 1);
      send(0, v, 1);
      chk(v[1] ? "R3 sweep" : "R2 sweep", pwr_down, v[1] ? pre : v[2]);
      chk_reg("R3 sweep reg", v[5:3], m_regs[v[5:3]]);
    end

    // R9 clock loss
    send(0, 8'h00, 1);
    fs_pulse(); fs_pulse();
    chk("R9 pre dx", dx_oe, 1);
    mclk_run = 0;
    repeat (40) @(negedge clk);
    chk("R9 not yet lost", clk_lost, 0); chk("R9 still up", pwr_down, 0);
    repeat (60) @(negedge clk);
    chk("R9 lost", clk_lost, 1); chk("R9 down", pwr_down, 1);
    chk("R9 codec_en", codec_en, 0); chk("R9 lo_oe", lo_oe, 0); chk("R9 dx_oe", dx_oe, 0);
    chk_reg("R9 reg3 kept", 3, 8'hA5); chk_reg("R9 reg0 kept", 0, 8'h66);

    // R10 leave loss only with clock present
    send(0, 8'h00, 1);
    chk("R10 ignored lost", clk_lost, 1); chk("R10 ignored down", pwr_down, 1);
    mclk_run = 1;
    repeat (10) @(negedge clk);
    chk("R10 lost until cmd", clk_lost, 1);
    send(0, 8'h00, 1);
    chk("R10 lost cleared", clk_lost, 0); chk("R10 up", pwr_down, 0); chk("R10 lo_oe", lo_oe, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule